// File: doc/BRIEF.md
# Co-processor Instruction Memory Loader

This block is the host-facing front end of a display co-processor. The host uses it to fill a 2 KB instruction store and to command the executor that runs the stored program. An 11-bit write pointer selects the byte in the store. The low eight bits of the pointer have their own register. The top three bits sit in the control register, next to a two-bit run mode. The store itself is organised as 1024 words of 16 bits. The loader drives its write port with a word index, a 16-bit data word and two byte-lane enables. Each instruction occupies one word: the byte at the even address is the high half and the byte at the odd address is the low half.

There are two ways to load data. The byte path writes one byte at the pointer and moves the pointer on. The word path keeps a byte written to an even address in a holding register and writes nothing. The byte that follows, at the odd address, completes the pair, and both halves go to the store in a single write. When the host writes the control register with a new run mode, the block sends the executor one single-cycle command pulse. The pulse asks it to start from the top, to resume where it stopped, or to start from the top and also restart at every frame origin. Writing back the mode that is already held sends no pulse, so the executor keeps its place.

Top module: `coproc_imem_loader`

## Requirements
- R1: After reset the pointer is 0, the run mode is 00, and `mem_we` and all three command pulses are low.
- R2: Selector code 1 writes `reg_wdata` into pointer bits 7:0. Selector code 2 writes pointer bits 10:8 from `reg_wdata[2:0]` and the run mode from `reg_wdata[7:6]`. With no write strobe, `reg_rdata` shows the pointer low byte for code 1 and {mode, 3'b000, pointer[10:8]} for code 2.
- R3: A write with selector code 0 at pointer A gives, one cycle later, a single-cycle `mem_we` with `mem_waddr` = A>>1 and the byte placed in both halves of `mem_wdata`. `mem_be` is 2'b10 (bits 15:8) when A is even and 2'b01 (bits 7:0) when A is odd. The pointer then reads A+1.
- R4: A write with selector code 3 at an even pointer produces no `mem_we`; it holds the byte and advances the pointer by one.
- R5: A write with selector code 3 at an odd pointer A gives, one cycle later, `mem_we` with `mem_be` = 2'b11, `mem_waddr` = A>>1 and `mem_wdata` = {held byte, new byte}, and advances the pointer by one.
- R6: A control write that changes the run mode to a non-zero value raises exactly one pulse for one cycle, in the cycle after the write: `exec_start` for 01, `exec_resume` for 10, `exec_frame_start` for 11. `exec_mode` shows the held mode.
- R7: A control write that leaves the mode unchanged, or that changes it to 00, raises no pulse.
- R8: Incrementing the pointer from 0x7FF gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 byte data, 1 pointer low, 2 control, 3 word data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the selected register |
| mem_we | output | 1 | Store write enable |
| mem_waddr | output | 10 | Store word index |
| mem_wdata | output | 16 | Store write data, even byte in bits 15:8 |
| mem_be | output | 2 | Byte-lane enables, bit 1 for bits 15:8 |
| exec_mode | output | 2 | Held run mode |
| exec_start | output | 1 | Pulse: run from index 0 and loop |
| exec_resume | output | 1 | Pulse: resume from last point and loop |
| exec_frame_start | output | 1 | Pulse: run from index 0 and restart at each frame origin |

## Verification
The bench loads bytes at both an even and an odd pointer. A design that swaps the lane mapping would write instructions with their halves exchanged. It also feeds a word pair in which the even byte must not reach the store early and the odd byte must commit both halves together. A loader that commits on every write would leave half-formed instructions in the store. The pointer is stepped across 0x7FF to check the wrap back to 0. The bench rewrites the run mode with its current value and expects no pulse; a design that fires anyway would restart a running program on every harmless rewrite.

// File: rtl/coproc_ldr_pkg.sv
package coproc_ldr_pkg;

  typedef enum logic [1:0] {
    SEL_BYTE_DATA = 2'd0,
    SEL_PTR_LO    = 2'd1,
    SEL_CTRL      = 2'd2,
    SEL_WORD_DATA = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    MODE_HALT   = 2'b00,
    MODE_START  = 2'b01,
    MODE_RESUME = 2'b10,
    MODE_FRAME  = 2'b11
  } run_mode_e;

  // Lane enable for a single byte: even address -> upper lane.
  function automatic logic [1:0] byte_lane(input logic odd);
    return odd ? 2'b01 : 2'b10;
  endfunction

endpackage

// File: rtl/cpl_ptr_ctr.sv
module cpl_ptr_ctr #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_lo,
  input  logic              set_hi,
  input  logic              step,
  input  logic [7:0]        wdata,
  output logic [ADDR_W-1:0] ptr
);
  localparam int HI_W = ADDR_W - 8;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (step) begin
      ptr <= bump(ptr);
    end else if (set_lo) begin
      ptr[7:0] <= wdata;
    end else if (set_hi) begin
      ptr[ADDR_W-1:8] <= wdata[HI_W-1:0];
    end
  end
endmodule

// File: rtl/cpl_word_pack.sv
module cpl_word_pack
  import coproc_ldr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_wr,
  input  logic              word_wr,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [7:0]        wdata,
  output logic              mem_we,
  output logic [ADDR_W-2:0] mem_waddr,
  output logic [15:0]       mem_wdata,
  output logic [1:0]        mem_be
);
  logic [7:0] held_q;
  logic       odd;
  assign odd = ptr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q    <= '0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
    end else begin
      mem_we <= 1'b0;
      mem_be <= 2'b00;
      if (byte_wr) begin
        mem_we    <= 1'b1;
        mem_waddr <= ptr[ADDR_W-1:1];
        mem_wdata <= {wdata, wdata};
        mem_be    <= byte_lane(odd);
      end else if (word_wr) begin
        if (!odd) begin
          held_q <= wdata;
        end else begin
          mem_we    <= 1'b1;
          mem_waddr <= ptr[ADDR_W-1:1];
          mem_wdata <= {held_q, wdata};
          mem_be    <= 2'b11;
        end
      end
    end
  end
endmodule

// File: rtl/cpl_mode_dec.sv
module cpl_mode_dec
  import coproc_ldr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [1:0] new_mode,
  output logic [1:0] mode,
  output logic       start_p,
  output logic       resume_p,
  output logic       frame_p
);
  logic changed;
  assign changed = ctrl_wr && (new_mode != mode) && (new_mode != MODE_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MODE_HALT;
      start_p  <= 1'b0;
      resume_p <= 1'b0;
      frame_p  <= 1'b0;
    end else begin
      if (ctrl_wr) mode <= new_mode;
      start_p  <= changed && (new_mode == MODE_START);
      resume_p <= changed && (new_mode == MODE_RESUME);
      frame_p  <= changed && (new_mode == MODE_FRAME);
    end
  end
endmodule

// File: rtl/coproc_imem_loader.sv
module coproc_imem_loader
  import coproc_ldr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              mem_we,
  output logic [ADDR_W-2:0] mem_waddr,
  output logic [15:0]       mem_wdata,
  output logic [1:0]        mem_be,
  output logic [1:0]        exec_mode,
  output logic              exec_start,
  output logic              exec_resume,
  output logic              exec_frame_start
);
  localparam int HI_W  = ADDR_W - 8;
  localparam int PAD_W = 6 - HI_W;

  logic [ADDR_W-1:0] cur_ptr;
  logic byte_wr, word_wr, ctrl_wr, lo_wr, ptr_step;

  assign byte_wr  = reg_wr && (reg_sel == SEL_BYTE_DATA);
  assign word_wr  = reg_wr && (reg_sel == SEL_WORD_DATA);
  assign ctrl_wr  = reg_wr && (reg_sel == SEL_CTRL);
  assign lo_wr    = reg_wr && (reg_sel == SEL_PTR_LO);
  assign ptr_step = byte_wr || word_wr;

  cpl_ptr_ctr #(.ADDR_W(ADDR_W)) ptr_i (
    .clk(clk), .rst_n(rst_n), .set_lo(lo_wr), .set_hi(ctrl_wr),
    .step(ptr_step), .wdata(reg_wdata), .ptr(cur_ptr)
  );

  cpl_word_pack #(.ADDR_W(ADDR_W)) pack_i (
    .clk(clk), .rst_n(rst_n), .byte_wr(byte_wr), .word_wr(word_wr),
    .ptr(cur_ptr), .wdata(reg_wdata), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_be(mem_be)
  );

  cpl_mode_dec mode_i (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .new_mode(reg_wdata[7:6]),
    .mode(exec_mode), .start_p(exec_start), .resume_p(exec_resume),
    .frame_p(exec_frame_start)
  );

  always_comb begin
    case (reg_sel)
      SEL_PTR_LO: reg_rdata = cur_ptr[7:0];
      SEL_CTRL:   reg_rdata = {exec_mode, {PAD_W{1'b0}}, cur_ptr[ADDR_W-1:8]};
      default:    reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/coproc_imem_loader_chk.sv
module coproc_imem_loader_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic              mem_we,
  input logic [1:0]        mem_be,
  input logic [1:0]        exec_mode,
  input logic              exec_start,
  input logic              exec_resume,
  input logic              exec_frame_start,
  input logic [ADDR_W-1:0] cur_ptr,
  input logic              ptr_step
);
  AST_WE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(reg_wr)); // R3
  AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be != 2'b11) |-> ($countones(mem_be) == 1)); // R3
  AST_EVEN_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd3 && !cur_ptr[0]) |=> !mem_we); // R4
  AST_FULL_WORD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be == 2'b11) |-> ($past(reg_sel) == 2'd3)); // R5
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({exec_start, exec_resume, exec_frame_start}) <= 1); // R6
  AST_START_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> (exec_mode == 2'b01)); // R6
  AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_start || exec_resume || exec_frame_start) |-> (exec_mode != $past(exec_mode))); // R7
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_step |=> (cur_ptr == ADDR_W'($past(cur_ptr) + 1'b1))); // R8
endmodule

bind coproc_imem_loader coproc_imem_loader_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .mem_we(mem_we), .mem_be(mem_be), .exec_mode(exec_mode),
  .exec_start(exec_start), .exec_resume(exec_resume),
  .exec_frame_start(exec_frame_start), .cur_ptr(cur_ptr), .ptr_step(ptr_step)
);

// File: tb/coproc_imem_loader_tb.sv
module coproc_imem_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic mem_we;
  logic [9:0] mem_waddr;
  logic [15:0] mem_wdata;
  logic [1:0] mem_be;
  logic [1:0] exec_mode;
  logic exec_start, exec_resume, exec_frame_start;

  int n_tests = 0;
  int n_fail = 0;

  // sampled after each write
  logic s_we;
  logic [9:0] s_waddr;
  logic [15:0] s_wdata;
  logic [1:0] s_be;
  logic [2:0] s_pulses;

  always #10 clk = ~clk;

  coproc_imem_loader dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .exec_mode(exec_mode), .exec_start(exec_start), .exec_resume(exec_resume),
    .exec_frame_start(exec_frame_start)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    s_we = mem_we; s_waddr = mem_waddr; s_wdata = mem_wdata; s_be = mem_be;
    s_pulses = {exec_start, exec_resume, exec_frame_start};
  endtask

  function automatic logic [10:0] read_ptr();
    return 11'h000;
  endfunction

  task automatic get_ptr(output logic [10:0] p);
    logic [7:0] lo;
    reg_sel = 2'd1; #1 lo = reg_rdata;
    reg_sel = 2'd2; #1 p = {reg_rdata[2:0], lo};
  endtask

  task automatic set_ptr(input logic [10:0] p, input logic [1:0] keep_mode);
    wr(2'd2, {keep_mode, 3'b000, p[10:8]});
    wr(2'd1, p[7:0]);
  endtask

  task automatic t_reset();
    logic [10:0] p;
    get_ptr(p);
    check("R1 ptr", p, 11'h0);
    check("R1 mode", exec_mode, 2'b00);
    check("R1 we", mem_we, 1'b0);
    check("R1 pulses", {exec_start, exec_resume, exec_frame_start}, 3'b000);
  endtask

  task automatic t_ptr_regs();
    logic [10:0] p;
    set_ptr(11'h5A3, 2'b00);
    get_ptr(p);
    check("R2 ptr readback", p, 11'h5A3);
    reg_sel = 2'd2; #1;
    check("R2 ctrl read", reg_rdata, 8'h05);
  endtask

  task automatic t_byte();
    logic [10:0] p;
    set_ptr(11'h124, 2'b00);
    wr(2'd0, 8'hC7);
    check("R3 even we", s_we, 1'b1);
    check("R3 even addr", s_waddr, 10'h092);
    check("R3 even data", s_wdata, 16'hC7C7);
    check("R3 even be", s_be, 2'b10);
    wr(2'd0, 8'h3E);
    check("R3 odd be", s_be, 2'b01);
    check("R3 odd addr", s_waddr, 10'h092);
    check("R3 odd data", s_wdata, 16'h3E3E);
    get_ptr(p);
    check("R3 ptr after", p, 11'h126);
    @(negedge clk);
    check("R3 single cycle", mem_we, 1'b0);
  endtask

  task automatic t_word();
    logic [10:0] p;
    set_ptr(11'h300, 2'b00);
    wr(2'd3, 8'hAB);
    check("R4 no write", s_we, 1'b0);
    get_ptr(p);
    check("R4 ptr", p, 11'h301);
    wr(2'd3, 8'hCD);
    check("R5 we", s_we, 1'b1);
    check("R5 be", s_be, 2'b11);
    check("R5 data", s_wdata, 16'hABCD);
    check("R5 addr", s_waddr, 10'h180);
    get_ptr(p);
    check("R5 ptr", p, 11'h302);
  endtask

  task automatic t_wrap();
    logic [10:0] p;
    set_ptr(11'h7FF, 2'b00);
    wr(2'd0, 8'h11);
    check("R8 addr", s_waddr, 10'h3FF);
    get_ptr(p);
    check("R8 wrap", p, 11'h000);
  endtask

  task automatic t_mode();
    wr(2'd2, 8'b01_000_000);
    check("R6 start", s_pulses, 3'b100);
    check("R6 mode", exec_mode, 2'b01);
    @(negedge clk);
    check("R6 one cycle", {exec_start, exec_resume, exec_frame_start}, 3'b000);
    wr(2'd2, 8'b01_000_011);
    check("R7 same mode", s_pulses, 3'b000);
    wr(2'd2, 8'b10_000_000);
    check("R6 resume", s_pulses, 3'b010);
    wr(2'd2, 8'b11_000_000);
    check("R6 frame", s_pulses, 3'b001);
    wr(2'd2, 8'b00_000_000);
    check("R7 halt", s_pulses, 3'b000);
    check("R7 mode halt", exec_mode, 2'b00);
    wr(2'd2, 8'b00_000_000);
    check("R7 halt again", s_pulses, 3'b000);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ptr_regs();
    t_byte();
    t_word();
    t_wrap();
    t_mode();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule